// File: doc/BRIEF.md
# Parallel-Port FIFO Service Interrupt Controller

This block decides when a parallel port's 16-entry byte FIFO needs attention from the host, and raises a level interrupt when it does. It does not hold the FIFO storage. It reads the FIFO's occupancy count and compares it against a programmable threshold. The comparison depends on the transfer direction. When the port sends data out, it compares the number of free entries. When the port receives data, it compares the number of filled entries. In DMA operation it reacts to the terminal-count pulse instead, and it provides the enable for the DMA request.

One master service-mask bit turns off both the DMA request and every service interrupt. Clearing that bit re-arms the logic. If the threshold condition already holds when the mask is cleared, the interrupt appears at once. The service condition is latched into a status bit. Software clears that bit by setting the mask again.

The block also watches two port pins, the fault line and the acknowledge line. Each pin passes through a synchronizer. A falling fault edge or a rising acknowledge edge, when enabled, is latched as a pin event. The interrupt output is the OR of the service status and the two pin-event latches.

Top module: `fifo_svc_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq`, `svc_status` and `dma_req_en` are all 0.
- R2: The effective threshold is `thr_code`+1, giving a range of 1 to 16. Consider the case `fifo_en`=1, `svc_mask`=0, `dma_en`=0 and `dir_read`=0 (sending). Here `svc_status` becomes 1 on the clock edge after the number of free entries (16 − `fifo_level`) reaches the threshold or more. Below the threshold it stays 0.
- R3: Consider the case `fifo_en`=1, `svc_mask`=0, `dma_en`=0 and `dir_read`=1 (receiving). Here `svc_status` becomes 1 on the clock edge after `fifo_level` is at or above `thr_code`+1. Below that level it stays 0.
- R4: While `svc_mask`=1, `dma_req_en` is 0. On the next edge `svc_status` is 0, and no service condition can set it.
- R5: With `fifo_en`=1, `dma_en`=1 and `svc_mask`=0, `dma_req_en` is 1. A one-cycle `dma_tc` pulse sets `svc_status` on that edge. The threshold comparison has no effect in this case.
- R6: When `svc_mask` changes from 1 to 0 while the threshold condition already holds, `svc_status` is set on the next edge.
- R7: Once set, `svc_status` stays 1 until `svc_mask` is 1, even if the condition that set it goes away.
- R8: With `fifo_en`=0, no threshold condition or `dma_tc` pulse sets `svc_status`, and `dma_req_en` is 0.
- R9: `fault_n_in` and `ack_n_in` pass through a 2-flop synchronizer. With `err_irq_dis`=0, a high-to-low change of `fault_n_in` sets the fault-event latch. As a result `irq` is 1 after the third rising edge following the pin change, and 0 after the second.
- R10: A change of `err_irq_dis` from 1 to 0 while the synchronized fault pin is low sets the fault-event latch on the next edge. While `err_irq_dis`=1, fault edges are ignored.
- R11: With `ack_irq_en`=1, a low-to-high change of `ack_n_in` sets the acknowledge-event latch, so that `irq` is 1 after the third edge. A falling edge, or any edge while `ack_irq_en`=0, has no effect.
- R12: A `pin_evt_clr` pulse clears both pin-event latches on that edge. `irq` equals `svc_status` OR either pin-event latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode selected |
| svc_mask | input | 1 | Master mask for DMA and service interrupts |
| dma_en | input | 1 | DMA operation selected |
| dir_read | input | 1 | 0 = sending out of the FIFO, 1 = receiving into it |
| thr_code | input | 4 | Programmed threshold minus one |
| fifo_level | input | 5 | FIFO occupancy, 0 to 16 |
| dma_tc | input | 1 | DMA terminal-count pulse |
| fault_n_in | input | 1 | Asynchronous fault pin, active low |
| ack_n_in | input | 1 | Asynchronous acknowledge pin |
| err_irq_dis | input | 1 | 1 disables fault interrupts |
| ack_irq_en | input | 1 | 1 enables acknowledge interrupts |
| pin_evt_clr | input | 1 | Clears both pin-event latches |
| irq | output | 1 | Level interrupt |
| svc_status | output | 1 | Latched service condition |
| dma_req_en | output | 1 | DMA request enable |

## Verification
The assertions check four behaviours on every cycle:
- The mask clears the status on the next edge.
- The status holds while the mask is clear.
- A disabled FIFO or an idle DMA transfer never sets the status.
- A clear pulse with no new event empties the pin latches, and an acknowledge event only latches when it was enabled.

Only the bench scenarios can show the following:
- The exact threshold boundaries in both directions, including the full range at code 15.
- The immediate set when the mask is cleared.
- The three-edge latency through the synchronizer.
- The interrupt raised when the fault enable is cleared while the pin is already low.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

    localparam int unsigned DEF_DEPTH  = 16;
    localparam int unsigned DEF_STAGES = 2;

    typedef enum logic {
        XFER_TO_PORT   = 1'b0,
        XFER_FROM_PORT = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic      enable;
        logic      mask;
        logic      dma;
        xfer_dir_e dir;
    } svc_cfg_t;

    typedef struct packed {
        logic fault_n;
        logic ack_n;
    } port_pins_t;

    typedef struct packed {
        logic fault;
        logic ack;
    } pin_evt_t;

    // Idle level of the port pins, used as synchronizer reset value
    localparam port_pins_t PINS_IDLE = '{fault_n: 1'b1, ack_n: 1'b1};

    function automatic logic any_evt(input pin_evt_t e);
        return e.fault | e.ack;
    endfunction

endpackage

// File: rtl/fsi_pin_sync.sv
module fsi_pin_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/fsi_thresh.sv
module fsi_thresh
    import fsi_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned THR_W = $clog2(DEPTH)
) (
    input  svc_cfg_t         cfg,
    input  logic [THR_W-1:0] thr_code,
    input  logic [CNT_W-1:0] level,
    output logic             met
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] thr_eff;
    logic [CNT_W-1:0] free_cnt;
    logic             fill_ok;
    logic             free_ok;

    always_comb begin
        thr_eff  = CNT_W'(thr_code) + CNT_W'(1);
        free_cnt = (level >= DEPTH_C) ? '0 : (DEPTH_C - level);
        fill_ok  = (level >= thr_eff);
        free_ok  = (free_cnt >= thr_eff);
        unique case (cfg.dir)
            XFER_FROM_PORT: met = cfg.enable & fill_ok;
            default:        met = cfg.enable & free_ok;
        endcase
    end

endmodule

// File: rtl/fsi_svc_latch.sv
module fsi_svc_latch
    import fsi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  svc_cfg_t cfg,
    input  logic     thr_met,
    input  logic     dma_tc,
    output logic     status,
    output logic     dma_req_en
);

    logic set_cond;

    always_comb begin
        if (!cfg.enable || cfg.mask) set_cond = 1'b0;
        else if (cfg.dma)            set_cond = dma_tc;
        else                         set_cond = thr_met;
    end

    always_ff @(posedge clk) begin
        if (rst)           status <= 1'b0;
        else if (cfg.mask) status <= 1'b0;
        else if (set_cond) status <= 1'b1;
    end

    assign dma_req_en = cfg.enable & cfg.dma & ~cfg.mask;

    // R4
    a_r4_mask_clears: assert property (@(posedge clk) disable iff (rst)
        cfg.mask |=> !status);

    // R7
    a_r7_status_holds: assert property (@(posedge clk) disable iff (rst)
        (status && !cfg.mask) |=> status);

    // R8
    a_r8_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        (!cfg.enable && !status) |=> !status);

    // R5
    a_r5_dma_needs_tc: assert property (@(posedge clk) disable iff (rst)
        (cfg.dma && !dma_tc && !status) |=> !status);

endmodule

// File: rtl/fsi_pin_events.sv
module fsi_pin_events
    import fsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_pins_t pins,
    input  logic       err_dis,
    input  logic       ack_en,
    input  logic       clr,
    output pin_evt_t   pend
);

    port_pins_t pins_q;
    logic       err_dis_q;
    pin_evt_t   hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q    <= PINS_IDLE;
            err_dis_q <= 1'b0;
        end else begin
            pins_q    <= pins;
            err_dis_q <= err_dis;
        end
    end

    always_comb begin
        hit.fault = ~err_dis & ((pins_q.fault_n & ~pins.fault_n) |
                                (err_dis_q & ~pins.fault_n));
        hit.ack   = ack_en & ~pins_q.ack_n & pins.ack_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend.fault <= hit.fault | (pend.fault & ~clr);
            pend.ack   <= hit.ack   | (pend.ack   & ~clr);
        end
    end

    // R12
    a_r12_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_evt(hit)) |=> (pend == '0));

    // R11
    a_r11_ack_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pend.ack) |-> $past(ack_en));

    // R10
    a_r10_fault_blocked: assert property (@(posedge clk) disable iff (rst)
        (err_dis && !pend.fault) |=> !pend.fault);

endmodule

// File: rtl/fifo_svc_irq_ctrl.sv
module fifo_svc_irq_ctrl
    import fsi_pkg::*;
#(
    parameter int unsigned DEPTH       = DEF_DEPTH,
    parameter int unsigned SYNC_STAGES = DEF_STAGES,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned THR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             svc_mask,
    input  logic             dma_en,
    input  logic             dir_read,
    input  logic [THR_W-1:0] thr_code,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic             dma_tc,
    input  logic             fault_n_in,
    input  logic             ack_n_in,
    input  logic             err_irq_dis,
    input  logic             ack_irq_en,
    input  logic             pin_evt_clr,
    output logic             irq,
    output logic             svc_status,
    output logic             dma_req_en
);

    svc_cfg_t   cfg;
    port_pins_t pins_raw;
    port_pins_t pins_sync;
    pin_evt_t   pend;
    logic       thr_met;

    always_comb begin
        cfg.enable = fifo_en;
        cfg.mask   = svc_mask;
        cfg.dma    = dma_en;
        cfg.dir    = dir_read ? XFER_FROM_PORT : XFER_TO_PORT;
        pins_raw.fault_n = fault_n_in;
        pins_raw.ack_n   = ack_n_in;
    end

    fsi_pin_sync #(
        .WIDTH   ($bits(port_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_raw),
        .q_sync  (pins_sync)
    );

    fsi_thresh #(.DEPTH(DEPTH)) u_thresh (
        .cfg      (cfg),
        .thr_code (thr_code),
        .level    (fifo_level),
        .met      (thr_met)
    );

    fsi_svc_latch u_svc (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .thr_met    (thr_met),
        .dma_tc     (dma_tc),
        .status     (svc_status),
        .dma_req_en (dma_req_en)
    );

    fsi_pin_events u_pins (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_sync),
        .err_dis (err_irq_dis),
        .ack_en  (ack_irq_en),
        .clr     (pin_evt_clr),
        .pend    (pend)
    );

    assign irq = svc_status | any_evt(pend);

    // R12
    a_r12_irq_follows_sources: assert property (@(posedge clk) disable iff (rst)
        (!svc_status && !$past(svc_status) && $stable(pin_evt_clr) && !pin_evt_clr && $past(!irq)
         && !$past(ack_irq_en) && $past(err_irq_dis) && err_irq_dis) |-> !irq);

endmodule

// File: tb/fifo_svc_irq_ctrl_test.sv
module fifo_svc_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 0, svc_mask = 1, dma_en = 0, dir_read = 0;
    logic [3:0] thr_code = 0;
    logic [4:0] fifo_level = 0;
    logic       dma_tc = 0, fault_n_in = 1, ack_n_in = 1;
    logic       err_irq_dis = 1, ack_irq_en = 0, pin_evt_clr = 0;
    logic       irq, svc_status, dma_req_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic  irq;
        logic  svc;
        logic  dma;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    fifo_svc_irq_ctrl uut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .svc_mask(svc_mask),
        .dma_en(dma_en), .dir_read(dir_read), .thr_code(thr_code),
        .fifo_level(fifo_level), .dma_tc(dma_tc), .fault_n_in(fault_n_in),
        .ack_n_in(ack_n_in), .err_irq_dis(err_irq_dis), .ack_irq_en(ack_irq_en),
        .pin_evt_clr(pin_evt_clr), .irq(irq), .svc_status(svc_status),
        .dma_req_en(dma_req_en)
    );

    // monitor: compares outputs just after the negedge on which an item was queued
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (irq !== e.irq || svc_status !== e.svc || dma_req_en !== e.dma) begin
                n_fail++;
                $display("FAIL %s: irq/svc/dma actual %b%b%b expected %b%b%b",
                         e.tag, irq, svc_status, dma_req_en, e.irq, e.svc, e.dma);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic i, input logic s, input logic d);
        exp_t e;
        e.irq = i; e.svc = s; e.dma = d; e.tag = tag;
        exp_q.push_back(e);
        #2;
    endtask

    task automatic clr_pins();
        pin_evt_clr = 1; step(1); pin_evt_clr = 0;
    endtask

    initial begin
        step(2);
        rst = 0;
        step(1);
        expect_out("R1 reset state", 0, 0, 0);

        // R8: FIFO disabled
        svc_mask = 0; thr_code = 0; fifo_level = 0; step(2);
        expect_out("R8 disabled no thr", 0, 0, 0);
        dma_en = 1; dma_tc = 1; step(1); dma_tc = 0; step(1);
        expect_out("R8 disabled tc ignored", 0, 0, 0);

        // R2: sending direction, threshold 4
        dma_en = 0; svc_mask = 1; fifo_en = 1; step(1);
        thr_code = 3; fifo_level = 13; svc_mask = 0; step(2);
        expect_out("R2 free 3 below thr 4", 0, 0, 0);
        fifo_level = 12; step(1);
        expect_out("R2 free 4 meets thr 4", 1, 1, 0);
        fifo_level = 16; step(1);
        expect_out("R7 holds after cond gone", 1, 1, 0);
        svc_mask = 1; step(1);
        expect_out("R4 mask clears", 0, 0, 0);

        // R6: re-enable with condition already met
        fifo_level = 0; thr_code = 15; step(2);
        expect_out("R4 masked while met", 0, 0, 0);
        svc_mask = 0; step(1);
        expect_out("R6 immediate on unmask", 1, 1, 0);

        // R3: receiving direction
        svc_mask = 1; step(1);
        dir_read = 1; thr_code = 7; fifo_level = 7; svc_mask = 0; step(2);
        expect_out("R3 fill 7 below thr 8", 0, 0, 0);
        fifo_level = 8; step(1);
        expect_out("R3 fill 8 meets thr 8", 1, 1, 0);
        svc_mask = 1; step(1);
        thr_code = 15; fifo_level = 15; svc_mask = 0; step(2);
        expect_out("R3 fill 15 below thr 16", 0, 0, 0);
        fifo_level = 16; step(1);
        expect_out("R3 fill 16 meets thr 16", 1, 1, 0);

        // R5: DMA
        svc_mask = 1; step(1);
        dma_en = 1; svc_mask = 0; step(1);
        expect_out("R5 dma req on, thr ignored", 0, 0, 1);
        dma_tc = 1; step(1); dma_tc = 0;
        expect_out("R5 tc sets status", 1, 1, 1);
        svc_mask = 1; step(1);
        expect_out("R4 mask drops dma req", 0, 0, 0);

        // R9: fault falling edge
        dma_en = 0; err_irq_dis = 0; fault_n_in = 0; step(2);
        expect_out("R9 not yet through sync", 0, 0, 0);
        step(1);
        expect_out("R9 fault edge latched", 1, 0, 0);
        clr_pins();
        expect_out("R12 clear pin latch", 0, 0, 0);
        fault_n_in = 1; step(4);

        // R10: enable cleared while fault low
        err_irq_dis = 1; fault_n_in = 0; step(4);
        expect_out("R10 disabled fault ignored", 0, 0, 0);
        err_irq_dis = 0; step(1);
        expect_out("R10 enable while low", 1, 0, 0);
        clr_pins(); fault_n_in = 1; err_irq_dis = 1; step(4);
        expect_out("R12 clear again", 0, 0, 0);

        // R11: acknowledge rising edge
        ack_n_in = 0; step(3); ack_n_in = 1; step(4);
        expect_out("R11 ack disabled ignored", 0, 0, 0);
        ack_irq_en = 1; ack_n_in = 0; step(4);
        expect_out("R11 falling ack ignored", 0, 0, 0);
        ack_n_in = 1; step(2);
        expect_out("R11 not yet through sync", 0, 0, 0);
        step(1);
        expect_out("R11 ack rise latched", 1, 0, 0);

        // R12: OR with service status, then clear pins
        svc_mask = 0; dir_read = 0; thr_code = 0; fifo_level = 0; step(1);
        expect_out("R12 both sources", 1, 1, 0);
        clr_pins();
        expect_out("R12 svc alone keeps irq", 1, 1, 0);
        svc_mask = 1; step(1);
        expect_out("R12 all clear", 0, 0, 0);

        step(2);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        step(1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule